// File: doc/BRIEF.md
# Preset-Loadable Up/Down Counter Channel

This block is one counter channel of 24 bits (three bytes by default) with a floor of zero, seen by a host through two byte-wide ports. Writes to the control port carry commands and configuration. Writes to the data port fill a preset register, and reads of the data port return a snapshot latch. The counter itself cannot be written. It is loaded only from the preset register and observed only through the latch. Count requests arrive as a count-enable pulse and a direction bit from an external decoder. Each enabled cycle gives one step, shaped by one of four count modes. In range-limit and modulo-N modes the preset also serves as the ceiling.

A byte sequencer shares one pointer between the preset writes and the latch reads. It has two named states. In SEQ_STEP the pointer advances on every data access, and on the access that reaches the top byte it moves to SEQ_PARK. In SEQ_PARK the pointer stays on the top byte. From either state, a pointer-reset command returns it to SEQ_STEP at byte 0.

The count core also has two named states. CORE_RUN accepts steps. In non-recycle mode, a step that carries or borrows moves it to CORE_HALT. CORE_HALT ignores steps and goes back to CORE_RUN on a counter clear or a preset load. A selectable source drives a one-cycle event pulse and a sticky pending bit.

Top module: `preset_counter_chan`

## Requirements
- R1: After reset the count is 0, the status byte reads 0x20, the prescaler output is 0, and event_pulse and irq_pending are 0.
- R2: On a control-port write, bits [6:5] select the target. 00 is a command, 01 sets the count mode from bits [2:1], 10 sets I/O control, and 11 sets the index level from bit 1 (1 = high active). In I/O control, bit 0 enables counting, bit 1 = 0 lets an index edge load the preset, and bits [4:3] pick the event source (0 carry, 1 compare, 2 carry or borrow, 3 index).
- R3: Data-port writes fill the preset least-significant byte first. After the top byte the pointer stays there, so extra writes overwrite the top byte. Command bit 0 returns the pointer to byte 0.
- R4: Command fields can be combined in one write. Bits [2:1]: 01 clears the counter, 10 clears carry/borrow/compare/sign, 11 clears the error flag. Bits [4:3]: 01 copies preset to counter, 10 copies counter to latch, 11 copies preset bits [7:0] to the prescaler output.
- R5: Data-port reads return the latch least-significant byte first through the same saturating pointer. Status-port reads do not move the pointer.
- R6: While the enable bit is 1, each cycle with cnt_en high makes one step, up when cnt_up is 1. The count shows the step at the next clock edge. With the enable bit 0, cnt_en has no effect. Status bit 5 holds the direction of the last step.
- R7: In normal mode (0) the count wraps between the all-ones value and 0. Status bit 0 (carry) is set by an up step from the top, bit 1 (borrow) by a down step from 0, and bit 3 (sign) is set by a borrow and cleared by a carry.
- R8: In range-limit mode (1) the count holds at the preset when stepping up from it and holds at 0 when stepping down from 0.
- R9: In modulo-N mode (3) the count goes from the preset to 0 when stepping up, and from 0 to the preset when stepping down.
- R10: In non-recycle mode (2) a carry or borrow freezes the counter until a counter clear or a preset load.
- R11: An index event is the index input entering its active level. When I/O bit 1 is 0, the event loads the preset into the counter. A counter clear beats a preset load, and both beat a step in the same cycle.
- R12: When the selected source fires, event_pulse is high for exactly one cycle after that clock edge and irq_pending becomes 1. irq_clr clears irq_pending unless a new event arrives in the same cycle. Compare (status bit 2) fires on a step that lands on the preset value.
- R13: A noise_hit pulse sets status bit 4, and it stays set until the clear-error command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_ctrl | input | 1 | 1 selects the control/status port, 0 the data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or current latch byte, combinational |
| cnt_en | input | 1 | Count request for this cycle |
| cnt_up | input | 1 | Direction of the request, 1 = up |
| index_in | input | 1 | Index signal level |
| noise_hit | input | 1 | Noise detected on the count inputs |
| irq_clr | input | 1 | Clears the pending bit |
| filt_prescale | output | 8 | Filter prescaler value |
| event_pulse | output | 1 | One-cycle event from the selected source |
| irq_pending | output | 1 | Sticky event indication |

## Verification
The hardest state to reach from the ports is CORE_HALT. To get there, the host must select non-recycle mode, push a value next to the top through the preset and transfer it, step across the boundary, and then prove that further steps do nothing, which it can only see through a latch snapshot. The directed part of the stimulus drives that sequence and then releases the halt with a preset load. The random part mixes all four modes with counts loaded near 0, near the top or at the ceiling, and compares every snapshot with a bench model. A second hard spot is the saturated byte pointer, which the stimulus reaches with four writes and four reads in a row.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL    = 2'd0,
        MODE_RANGE     = 2'd1,
        MODE_NORECYCLE = 2'd2,
        MODE_MODULO    = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        EV_CARRY   = 2'd0,
        EV_COMPARE = 2'd1,
        EV_WRAP    = 2'd2,
        EV_INDEX   = 2'd3
    } ev_src_e;

    typedef enum logic [1:0] {
        REG_CMD   = 2'd0,
        REG_MODE  = 2'd1,
        REG_IOCTL = 2'd2,
        REG_INDEX = 2'd3
    } reg_sel_e;

    typedef enum logic { SEQ_STEP = 1'b0, SEQ_PARK = 1'b1 } seq_state_e;
    typedef enum logic { CORE_RUN = 1'b0, CORE_HALT = 1'b1 } core_state_e;

    // status byte bits [5:0]
    typedef struct packed {
        logic up;
        logic err;
        logic sign;
        logic cmp;
        logic borrow;
        logic carry;
    } flags_t;
endpackage

// File: rtl/pcc_byte_seq.sv
`timescale 1ns/1ps
module pcc_byte_seq
    import pcc_pkg::*;
#(
    parameter int NBYTES = 3,
    localparam int IW = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rewind,
    input  logic          advance,
    output logic [IW-1:0] idx
);
    seq_state_e    st_q, st_d;
    logic [IW-1:0] idx_q, idx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SEQ_STEP;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        if (rewind) begin
            st_d  = SEQ_STEP;
            idx_d = '0;
        end else if (advance) begin
            unique case (st_q)
                SEQ_STEP: begin
                    idx_d = idx_q + 1'b1;
                    if (idx_q == IW'(NBYTES - 2)) st_d = SEQ_PARK;
                end
                SEQ_PARK: idx_d = idx_q;
                default:  st_d = SEQ_STEP;
            endcase
        end
    end

    assign idx = idx_q;
endmodule

// File: rtl/pcc_count_core.sv
`timescale 1ns/1ps
module pcc_count_core
    import pcc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] ceil,
    input  logic             step_en,
    input  logic             up,
    input  logic             zero_ld,
    input  logic             preset_ld,
    input  logic             flag_clr,
    input  logic             err_clr,
    input  logic             noise_hit,
    input  ev_src_e          ev_sel,
    input  logic             idx_evt,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] count,
    output flags_t           flags,
    output logic             halted,
    output logic             live,
    output logic             event_pulse,
    output logic             irq_pending
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    core_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, top_val, stepped;
    logic             at_top, at_bot, carry_now, borrow_now, cmp_now, ev_now;
    flags_t           fl_q;
    logic             pulse_q, pend_q;

    always_comb begin
        top_val    = (mode == MODE_RANGE || mode == MODE_MODULO) ? ceil : ALL_ONES;
        live       = step_en && (st_q == CORE_RUN) && !zero_ld && !preset_ld;
        at_top     = (cnt_q == top_val);
        at_bot     = (cnt_q == '0);
        carry_now  = live && up && at_top;
        borrow_now = live && !up && at_bot;
        if (up)
            stepped = at_top ? ((mode == MODE_RANGE) ? cnt_q : '0) : cnt_q + 1'b1;
        else
            stepped = at_bot ? ((mode == MODE_RANGE) ? cnt_q : top_val) : cnt_q - 1'b1;
        cmp_now = live && (stepped == ceil);

        cnt_d = cnt_q;
        st_d  = st_q;
        if (zero_ld) begin
            cnt_d = '0;
            st_d  = CORE_RUN;
        end else if (preset_ld) begin
            cnt_d = ceil;
            st_d  = CORE_RUN;
        end else if (live) begin
            cnt_d = stepped;
            if (mode == MODE_NORECYCLE && (carry_now || borrow_now)) st_d = CORE_HALT;
        end

        unique case (ev_sel)
            EV_CARRY:   ev_now = carry_now;
            EV_COMPARE: ev_now = cmp_now;
            EV_WRAP:    ev_now = carry_now || borrow_now;
            EV_INDEX:   ev_now = idx_evt;
            default:    ev_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= CORE_RUN;
            cnt_q   <= '0;
            fl_q    <= '{up: 1'b1, default: 1'b0};
            pulse_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (flag_clr) begin
                fl_q.carry  <= 1'b0;
                fl_q.borrow <= 1'b0;
                fl_q.cmp    <= 1'b0;
                fl_q.sign   <= 1'b0;
            end else begin
                if (carry_now)  fl_q.carry  <= 1'b1;
                if (borrow_now) fl_q.borrow <= 1'b1;
                if (cmp_now)    fl_q.cmp    <= 1'b1;
                if (borrow_now)     fl_q.sign <= 1'b1;
                else if (carry_now) fl_q.sign <= 1'b0;
            end
            fl_q.err <= noise_hit | (fl_q.err & ~err_clr);
            if (live) fl_q.up <= up;
            pulse_q <= ev_now;
            pend_q  <= ev_now | (pend_q & ~irq_clr);
        end
    end

    assign count       = cnt_q;
    assign flags       = fl_q;
    assign halted      = (st_q == CORE_HALT);
    assign event_pulse = pulse_q;
    assign irq_pending = pend_q;
endmodule

// File: rtl/preset_counter_chan.sv
`timescale 1ns/1ps
module preset_counter_chan
    import pcc_pkg::*;
#(
    parameter int CNT_BYTES = 3,
    localparam int CNT_W = 8 * CNT_BYTES,
    localparam int IW = $clog2(CNT_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_ctrl,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       cnt_en,
    input  logic       cnt_up,
    input  logic       index_in,
    input  logic       noise_hit,
    input  logic       irq_clr,
    output logic [7:0] filt_prescale,
    output logic       event_pulse,
    output logic       irq_pending
);
    reg_sel_e         wsel;
    logic             ctl_wr, dat_wr, dat_rd, cmd;
    logic             rewind, zero_ld, flag_clr, err_clr, pre_cmd, snap, psc_ld;
    logic             preset_ld, idx_act, idx_evt, step_req;
    logic [IW-1:0]    byte_idx;
    logic [CNT_W-1:0] preset_q, latch_q, count_w;
    logic [7:0]       presc_q;
    cnt_mode_e        mode_q;
    ev_src_e          ev_q;
    logic             io_en_q, pld_n_q, pol_q, idx_prev_q;
    logic             halted_w, live_w;
    flags_t           flags_w;
    logic             unused_wbit;

    assign unused_wbit = host_wdata[7];

    assign wsel     = reg_sel_e'(host_wdata[6:5]);
    assign ctl_wr   = host_wr && host_ctrl;
    assign dat_wr   = host_wr && !host_ctrl;
    assign dat_rd   = host_rd && !host_ctrl;
    assign cmd      = ctl_wr && (wsel == REG_CMD);
    assign rewind   = cmd && host_wdata[0];
    assign zero_ld  = cmd && (host_wdata[2:1] == 2'b01);
    assign flag_clr = cmd && (host_wdata[2:1] == 2'b10);
    assign err_clr  = cmd && (host_wdata[2:1] == 2'b11);
    assign pre_cmd  = cmd && (host_wdata[4:3] == 2'b01);
    assign snap     = cmd && (host_wdata[4:3] == 2'b10);
    assign psc_ld   = cmd && (host_wdata[4:3] == 2'b11);

    assign idx_act   = (index_in == pol_q);
    assign idx_evt   = idx_act && !idx_prev_q;
    assign preset_ld = pre_cmd || (idx_evt && !pld_n_q);
    assign step_req  = cnt_en && io_en_q;

    pcc_byte_seq #(.NBYTES(CNT_BYTES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rewind  (rewind),
        .advance (dat_wr || dat_rd),
        .idx     (byte_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_NORMAL;
            ev_q       <= EV_CARRY;
            io_en_q    <= 1'b0;
            pld_n_q    <= 1'b1;
            pol_q      <= 1'b1;
            idx_prev_q <= 1'b1;
            preset_q   <= '0;
            latch_q    <= '0;
            presc_q    <= '0;
        end else begin
            idx_prev_q <= idx_act;
            if (ctl_wr) begin
                unique case (wsel)
                    REG_CMD:   ;
                    REG_MODE:  mode_q <= cnt_mode_e'(host_wdata[2:1]);
                    REG_IOCTL: begin
                        io_en_q <= host_wdata[0];
                        pld_n_q <= host_wdata[1];
                        ev_q    <= ev_src_e'(host_wdata[4:3]);
                    end
                    REG_INDEX: pol_q <= host_wdata[1];
                    default:   ;
                endcase
            end
            if (dat_wr) preset_q[int'(byte_idx)*8 +: 8] <= host_wdata;
            if (snap)   latch_q <= count_w;
            if (psc_ld) presc_q <= preset_q[7:0];
        end
    end

    pcc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_q),
        .ceil        (preset_q),
        .step_en     (step_req),
        .up          (cnt_up),
        .zero_ld     (zero_ld),
        .preset_ld   (preset_ld),
        .flag_clr    (flag_clr),
        .err_clr     (err_clr),
        .noise_hit   (noise_hit),
        .ev_sel      (ev_q),
        .idx_evt     (idx_evt),
        .irq_clr     (irq_clr),
        .count       (count_w),
        .flags       (flags_w),
        .halted      (halted_w),
        .live        (live_w),
        .event_pulse (event_pulse),
        .irq_pending (irq_pending)
    );

    assign host_rdata    = host_ctrl ? {2'b00, flags_w} : latch_q[int'(byte_idx)*8 +: 8];
    assign filt_prescale = presc_q;
endmodule

// File: rtl/pcc_checker.sv
`timescale 1ns/1ps
module pcc_checker #(
    parameter int CNT_W = 24,
    parameter int IW = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_ctrl,
    input logic [7:0]       host_wdata,
    input logic             cnt_up,
    input logic             irq_clr,
    input logic             event_pulse,
    input logic             irq_pending,
    input logic [IW-1:0]    byte_idx,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] preset,
    input logic [1:0]       mode,
    input logic             live,
    input logic             halted,
    input logic             zero_ld,
    input logic             preset_ld
);
    p_ptr_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_ctrl && host_wdata[6:5] == 2'b00 && host_wdata[0]) |=> (byte_idx == '0));

    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_ctrl && host_wdata[6:5] == 2'b00 && host_wdata[2:1] == 2'b01) |=> (count == '0));

    p_normal_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && mode == 2'd0) |=> !$stable(count));

    p_range_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && mode == 2'd1 && cnt_up && count == preset) |=> $stable(count));

    p_modulo_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live && mode == 2'd3 && cnt_up && count == preset) |=> (count == '0));

    p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !zero_ld && !preset_ld) |=> $stable(count));

    p_pulse_sets_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> irq_pending);

    p_clear_drops_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && irq_pending) |=> (!irq_pending || event_pulse));
endmodule

bind preset_counter_chan pcc_checker #(.CNT_W(CNT_W), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_ctrl   (host_ctrl),
    .host_wdata  (host_wdata),
    .cnt_up      (cnt_up),
    .irq_clr     (irq_clr),
    .event_pulse (event_pulse),
    .irq_pending (irq_pending),
    .byte_idx    (byte_idx),
    .count       (count_w),
    .preset      (preset_q),
    .mode        (mode_q),
    .live        (live_w),
    .halted      (halted_w),
    .zero_ld     (zero_ld),
    .preset_ld   (preset_ld)
);

// File: tb/tb_preset_counter_chan.sv
`timescale 1ns/1ps
module tb_preset_counter_chan;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 0, host_rd = 0, host_ctrl = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       cnt_en = 0, cnt_up = 0, index_in = 0, noise_hit = 0, irq_clr = 0;
    logic [7:0] filt_prescale;
    logic       event_pulse, irq_pending;

    int errs = 0;
    int checks = 0;
    int ev_seen = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    preset_counter_chan dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_ctrl(host_ctrl), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cnt_en(cnt_en), .cnt_up(cnt_up), .index_in(index_in),
        .noise_hit(noise_hit), .irq_clr(irq_clr), .filt_prescale(filt_prescale),
        .event_pulse(event_pulse), .irq_pending(irq_pending)
    );

    always @(negedge clk) if (rst_n && event_pulse) ev_seen++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ctl(input logic [7:0] b);
        @(negedge clk); host_ctrl = 1; host_wr = 1; host_wdata = b;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic dwr(input logic [7:0] b);
        @(negedge clk); host_ctrl = 0; host_wr = 1; host_wdata = b;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic drd(output logic [7:0] b);
        @(negedge clk); host_ctrl = 0; host_rd = 1; #1 b = host_rdata;
        @(negedge clk); host_rd = 0;
    endtask

    task automatic srd(output logic [7:0] b);
        @(negedge clk); host_ctrl = 1; #1 b = host_rdata;
    endtask

    task automatic set_preset(input logic [23:0] p);
        ctl(8'h01); dwr(p[7:0]); dwr(p[15:8]); dwr(p[23:16]);
    endtask

    task automatic load_count(input logic [23:0] v, input logic [23:0] p);
        set_preset(v); ctl(8'h08); set_preset(p);
    endtask

    task automatic read_count(output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        ctl(8'h11); drd(b0); drd(b1); drd(b2);
        v = {b2, b1, b0};
    endtask

    task automatic run(input int n, input logic up);
        @(negedge clk); cnt_up = up; cnt_en = 1;
        repeat (n) @(negedge clk);
        cnt_en = 0;
    endtask

    task automatic pulse_index(input int hi);
        @(negedge clk); index_in = 1;
        repeat (hi) @(negedge clk);
        index_in = 0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [24:0] mstep(input logic [1:0] mode, input logic [23:0] c,
                                          input logic [23:0] p, input logic up, input logic halt);
        logic [23:0] top;
        top = (mode == 2'd1 || mode == 2'd3) ? p : 24'hFFFFFF;
        if (halt) return {1'b1, c};
        if (up) begin
            if (c == top) return {(mode == 2'd2), (mode == 2'd1) ? c : 24'h0};
            return {1'b0, c + 24'd1};
        end
        if (c == 24'h0) return {(mode == 2'd2), (mode == 2'd1) ? c : top};
        return {1'b0, c - 24'd1};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [23:0] v;
        int e0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        srd(b);
        chk("R1 status", b, 8'h20);
        chk("R1 irq", irq_pending, 0);
        chk("R1 pulse", event_pulse, 0);
        chk("R1 prescale", filt_prescale, 0);
        read_count(v);
        chk("R1 count", v, 0);

        // R3 R4 R5 preset load and snapshot
        load_count(24'h123456, 24'h0);
        read_count(v);
        chk("R4 preset to counter", v, 24'h123456);

        // R3 saturating pointer on writes
        ctl(8'h01); dwr(8'hAA); dwr(8'hBB); dwr(8'hCC); dwr(8'hDD); ctl(8'h08);
        read_count(v);
        chk("R3 saturated write", v, 24'hDDBBAA);
        ctl(8'h18);
        chk("R4 prescaler", filt_prescale, 8'hAA);

        // R5 saturating reads, status read leaves pointer
        ctl(8'h11); drd(b); drd(b); drd(b); drd(b);
        chk("R5 fourth read", b, 8'hDD);
        ctl(8'h11); drd(b); srd(b); drd(b);
        chk("R5 status no move", b, 8'hBB);

        // R4 clear counter
        ctl(8'h02);
        read_count(v);
        chk("R4 clear", v, 0);

        // R6 R7 normal counting
        ctl(8'h43); ctl(8'h20); ctl(8'h04);
        run(5, 1);
        read_count(v);
        chk("R6 count up", v, 5);
        srd(b);
        chk("R6 dir up", b[5], 1);
        ctl(8'h42);
        run(3, 1);
        read_count(v);
        chk("R6 disabled ignored", v, 5);
        ctl(8'h43);
        run(7, 0);
        read_count(v);
        chk("R7 wrap down", v, 24'hFFFFFE);
        srd(b);
        chk("R7 borrow status", b, 8'h0A);
        e0 = ev_seen;
        run(2, 1);
        repeat (2) @(negedge clk);
        read_count(v);
        chk("R7 wrap up", v, 0);
        srd(b);
        chk("R7 carry status", b, 8'h23);
        chk("R12 carry event once", ev_seen - e0, 1);
        chk("R12 pending set", irq_pending, 1);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
        chk("R12 pending cleared", irq_pending, 0);

        // R8 range limit
        ctl(8'h22);
        load_count(24'd8, 24'd10);
        run(5, 1);
        read_count(v);
        chk("R8 hold at ceiling", v, 10);
        run(12, 0);
        read_count(v);
        chk("R8 hold at zero", v, 0);

        // R9 modulo-N
        ctl(8'h26);
        load_count(24'd3, 24'd4);
        run(3, 1);
        read_count(v);
        chk("R9 wrap up", v, 1);
        run(3, 0);
        read_count(v);
        chk("R9 wrap down", v, 3);

        // R10 non-recycle
        ctl(8'h24);
        load_count(24'hFFFFFE, 24'd5);
        run(5, 1);
        read_count(v);
        chk("R10 frozen after carry", v, 0);
        ctl(8'h08);
        run(2, 1);
        read_count(v);
        chk("R10 resumes after load", v, 7);

        // R11 index load
        ctl(8'h20); ctl(8'h62); ctl(8'h41);
        load_count(24'd100, 24'h000777);
        pulse_index(3);
        read_count(v);
        chk("R11 index loads preset", v, 24'h000777);
        ctl(8'h43);
        load_count(24'd100, 24'h000777);
        pulse_index(3);
        read_count(v);
        chk("R11 index load disabled", v, 100);
        ctl(8'h5B);
        e0 = ev_seen;
        pulse_index(3);
        chk("R12 index event once", ev_seen - e0, 1);
        chk("R12 index pending", irq_pending, 1);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
        ctl(8'h60);
        repeat (3) @(negedge clk);
        e0 = ev_seen;
        @(negedge clk); index_in = 1;
        repeat (2) @(negedge clk); index_in = 0;
        repeat (3) @(negedge clk);
        chk("R2 low-active index edge", ev_seen - e0, 1);
        ctl(8'h62);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;

        // R13 noise error
        srd(b);
        chk("R13 error clear before", b[4], 0);
        @(negedge clk); noise_hit = 1;
        @(negedge clk); noise_hit = 0;
        srd(b);
        chk("R13 error set", b[4], 1);
        ctl(8'h06);
        srd(b);
        chk("R13 error cleared", b[4], 0);

        // R12 compare event
        ctl(8'h04); ctl(8'h4B); ctl(8'h20);
        load_count(24'd0, 24'd3);
        e0 = ev_seen;
        run(3, 1);
        repeat (2) @(negedge clk);
        srd(b);
        chk("R12 compare flag", b[2], 1);
        chk("R12 compare event", ev_seen - e0, 1);

        // R6 R7 R8 R9 R10 random mode mix against model
        ctl(8'h43);
        for (int it = 0; it < 30; it++) begin
            logic [1:0]  md;
            logic [23:0] p, c;
            logic        halt;
            logic [24:0] r;
            md = 2'($urandom % 4);
            p  = 24'($urandom % 16 + 1);
            if (md == 2'd1 || md == 2'd3) c = 24'($urandom % (p + 1));
            else if ($urandom % 2 == 0) c = 24'($urandom % 8);
            else c = 24'hFFFFF8 + 24'($urandom % 8);
            ctl(8'h20 | {5'b0, md, 1'b0});
            load_count(c, p);
            halt = 0;
            for (int k = 0; k < 3; k++) begin
                int n;
                logic u;
                n = 1 + int'($urandom % 12);
                u = 1'($urandom % 2);
                run(n, u);
                for (int s = 0; s < n; s++) begin
                    r = mstep(md, c, p, u, halt);
                    halt = r[24];
                    c = r[23:0];
                end
            end
            read_count(v);
            chk($sformatf("R8/R9/R10 random mode %0d R6", md), v, c);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule